// File: doc/BRIEF.md
# Dual-Clock Activity Monitor with Automatic Failover

This block watches two clock sources, an internal oscillator and an external oscillator, from a third free-running sample clock. Each monitored clock drives a toggle flop. The toggle is brought into the sample domain through a two-flop synchronizer. A per-source window counter then declares the source dead when no edge arrives within `WINDOW` sample cycles. When a source dies while monitoring is enabled, three things happen:

- The block sets a sticky failure flag.
- It switches its select output to the surviving source.
- It can raise an interrupt.

The block only reports which source should be selected. The clock multiplexer, the oscillators and their trimming sit outside it.

Software sees one 8-bit register through single-cycle read and write strobes in the sample-clock domain. Layout:

| Bit | Access | Function |
|-----|--------|----------|
| 0 | control | external oscillator on |
| 1 | control | select external |
| 2 | control | monitor enable |
| 3 | control | interrupt enable |
| 4 | status | internal stable |
| 5 | status | external stable |
| 6 | flag | failure flag |
| 7 | — | reads zero |

The two stability inputs are assumed synchronous to the sample clock. Clearing the failure flag is a two-step handshake: a read that sees the flag set, then a later write of zero to bit 6.

Top module: `clk_mon_failover`

## Requirements
- R1: A write of 1 to bit 2 (monitor enable) takes effect only if `int_stable_i` or `ext_stable_i` is high in that cycle. Otherwise bit 2 stays 0. Writing 0 to bit 2 always clears it.
- R2: Once set, monitor enable stays set when both stability inputs later drop. It is cleared only by a software write of 0 to bit 2.
- R3: While monitoring is enabled, a source with no edge for `WINDOW` (default 16) sample cycles sets the failure flag (bit 6). A source still toggling never sets it. The flag is not set earlier than `WINDOW` cycles after the last synchronized edge.
- R4: On a failure of one source, bit 1 and `sel_ext_o` switch to the other source without software action: 1 after an internal failure, 0 after an external failure.
- R5: A write with bit 6 = 0 clears the flag if a read since the last failure saw the flag set.
- R6: A write with bit 6 = 1 leaves the flag unchanged.
- R7: A write with bit 6 = 0 leaves the flag set in two cases: no read saw it set, or a new failure occurred between that read and the write.
- R8: `irq_o` is high exactly while the flag (bit 6) and interrupt enable (bit 3) are both 1.
- R9: With monitor enable at 0, a stopped source sets no flag and changes no selection.
- R10: Reset clears all control bits and the flag. The internal source is selected (`sel_ext_o` = 0) and `irq_o` = 0.
- R11: Bits 0, 1 and 3 read back as written. Bit 0 drives `ext_osc_on_o` and bit 1 drives `sel_ext_o`. Bits 4 and 5 reflect `int_stable_i` and `ext_stable_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | free-running sample clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| int_clk_i | input | 1 | monitored internal clock |
| ext_clk_i | input | 1 | monitored external clock |
| int_stable_i | input | 1 | internal source stable indication |
| ext_stable_i | input | 1 | external source stable indication |
| reg_wr_i | input | 1 | register write strobe |
| reg_rd_i | input | 1 | register read strobe |
| reg_wdata_i | input | 8 | register write data |
| reg_rdata_o | output | 8 | register read data |
| ext_osc_on_o | output | 1 | external oscillator enable |
| sel_ext_o | output | 1 | selected source, 1 = external |
| irq_o | output | 1 | failure interrupt request |

## Verification
Register writes take effect at the first sample edge after the strobe. Read data is combinational, so the bench drives strobes on the falling edge and samples outputs one falling edge later.

Failure detection spans an asynchronous boundary, so its latency is only bounded. A dead source is reported between roughly `WINDOW`+3 and `WINDOW`+3+one monitored period sample cycles after its last edge. The bench therefore stops a clock right after one of its rising edges. It checks that the flag is still clear 10 cycles later (below the window) and that the flag and the failover are present 60 cycles later. Flag and interrupt effects of the clear handshake are checked one cycle after each strobe.

// File: rtl/clk_mon_pkg.sv
package clk_mon_pkg;
  localparam int NUM_SRC   = 2;
  localparam int SRC_INT   = 0;
  localparam int SRC_EXT   = 1;
  // register bit positions
  localparam int B_EXT_ON  = 0;
  localparam int B_SEL_EXT = 1;
  localparam int B_MON_EN  = 2;
  localparam int B_IRQ_EN  = 3;
  localparam int B_INT_STB = 4;
  localparam int B_EXT_STB = 5;
  localparam int B_FLAG    = 6;
  localparam int REG_W     = 8;

  typedef struct packed {
    logic irq_en;
    logic mon_en;
    logic sel_ext;
    logic ext_on;
  } ctl_t;
endpackage

// File: rtl/clk_act_det.sv
module clk_act_det #(
  parameter int WINDOW = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mon_clk_i,
  input  logic en_i,
  output logic fail_o
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LIM = CW'(WINDOW);

  logic          tgl_q;
  logic [2:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          act;

  always_ff @(posedge mon_clk_i or negedge rst_ni)
    if (!rst_ni) tgl_q <= 1'b0;
    else         tgl_q <= ~tgl_q;

  // two sync stages plus one history stage for edge detect
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], tgl_q};

  assign act = sync_q[2] ^ sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i || act)  cnt_q <= '0;
    else if (cnt_q != LIM)  cnt_q <= cnt_q + 1'b1;

  // single pulse when the window expires
  assign fail_o = en_i && !act && (cnt_q == LIM - 1'b1);
endmodule

// File: rtl/clk_mon_regs.sv
module clk_mon_regs
  import clk_mon_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic               int_stable_i,
  input  logic               ext_stable_i,
  input  logic [NUM_SRC-1:0] fail_i,
  output ctl_t               ctl_o,
  output logic               flag_o
);
  ctl_t ctl_q;
  logic flag_q, arm_q, clr;
  logic unused_wdata;

  assign unused_wdata = ^{wdata_i[REG_W-1], wdata_i[B_EXT_STB], wdata_i[B_INT_STB]};
  assign clr = wr_i && !wdata_i[B_FLAG] && arm_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ctl_q <= '0;
    end else begin
      if (wr_i) begin
        ctl_q.ext_on  <= wdata_i[B_EXT_ON];
        ctl_q.sel_ext <= wdata_i[B_SEL_EXT];
        ctl_q.irq_en  <= wdata_i[B_IRQ_EN];
        ctl_q.mon_en  <= wdata_i[B_MON_EN] &&
                         (ctl_q.mon_en || int_stable_i || ext_stable_i);
      end
      if (fail_i[SRC_INT] && !fail_i[SRC_EXT])      ctl_q.sel_ext <= 1'b1;
      else if (fail_i[SRC_EXT] && !fail_i[SRC_INT]) ctl_q.sel_ext <= 1'b0;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (|fail_i) begin
        flag_q <= 1'b1;
        arm_q  <= 1'b0;
      end else if (clr) begin
        flag_q <= 1'b0;
        arm_q  <= 1'b0;
      end else if (rd_i && flag_q) begin
        arm_q  <= 1'b1;
      end
    end

  assign ctl_o  = ctl_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/clk_mon_failover.sv
module clk_mon_failover
  import clk_mon_pkg::*;
#(
  parameter int WINDOW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             int_clk_i,
  input  logic             ext_clk_i,
  input  logic             int_stable_i,
  input  logic             ext_stable_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             ext_osc_on_o,
  output logic             sel_ext_o,
  output logic             irq_o
);
  logic [NUM_SRC-1:0] src_clk;
  logic [NUM_SRC-1:0] fail;
  ctl_t               ctl;
  logic               flag;

  assign src_clk[SRC_INT] = int_clk_i;
  assign src_clk[SRC_EXT] = ext_clk_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_det
    clk_act_det #(.WINDOW(WINDOW)) det_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mon_clk_i(src_clk[g]),
      .en_i     (ctl.mon_en),
      .fail_o   (fail[g])
    );
  end

  clk_mon_regs regs_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .rd_i        (reg_rd_i),
    .wdata_i     (reg_wdata_i),
    .int_stable_i(int_stable_i),
    .ext_stable_i(ext_stable_i),
    .fail_i      (fail),
    .ctl_o       (ctl),
    .flag_o      (flag)
  );

  always_comb begin
    reg_rdata_o            = '0;
    reg_rdata_o[B_EXT_ON]  = ctl.ext_on;
    reg_rdata_o[B_SEL_EXT] = ctl.sel_ext;
    reg_rdata_o[B_MON_EN]  = ctl.mon_en;
    reg_rdata_o[B_IRQ_EN]  = ctl.irq_en;
    reg_rdata_o[B_INT_STB] = int_stable_i;
    reg_rdata_o[B_EXT_STB] = ext_stable_i;
    reg_rdata_o[B_FLAG]    = flag;
  end

  assign ext_osc_on_o = ctl.ext_on;
  assign sel_ext_o    = ctl.sel_ext;
  assign irq_o        = flag && ctl.irq_en;
endmodule

// File: rtl/clk_mon_failover_chk.sv
module clk_mon_failover_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       int_stable_i,
  input logic       ext_stable_i,
  input logic       reg_wr_i,
  input logic       reg_rd_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       sel_ext_o,
  input logic       irq_o
);
  logic unused_rd;
  assign unused_rd = reg_rd_i;

  assert_mon_gate_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_wdata_i[2] && !reg_rdata_o[2] && !int_stable_i && !ext_stable_i)
    |=> !reg_rdata_o[2]);

  assert_mon_persist_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[2] && !(reg_wr_i && !reg_wdata_i[2])) |=> reg_rdata_o[2]);

  assert_flag_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reg_rdata_o[6]) |-> $past(reg_wr_i && !reg_wdata_i[6]));

  assert_flag_w1_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[6] && reg_wr_i && reg_wdata_i[6]) |=> reg_rdata_o[6]);

  assert_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (reg_rdata_o[6] && reg_rdata_o[3]));

  assert_flag_needs_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_rdata_o[6]) |-> $past(reg_rdata_o[2]));

  assert_sel_port_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ext_o == reg_rdata_o[1]);
endmodule

bind clk_mon_failover clk_mon_failover_chk chk_i (.*);

// File: tb/clk_mon_failover_tb_top.sv
`timescale 1ns/1ps
module clk_mon_failover_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       int_clk = 1'b0, ext_clk = 1'b0;
  logic       int_run = 1'b1, ext_run = 1'b1;
  logic       int_stb = 1'b0, ext_stb = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ext_on, sel_ext, irq;
  logic [3:0] ctl = '0;
  logic [7:0] rv;
  int         errors = 0, checks = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;
  always begin #20; if (int_run) int_clk = ~int_clk; end
  always begin #30; if (ext_run) ext_clk = ~ext_clk; end

  clk_mon_failover dut_i (
    .clk_i(clk), .rst_ni(rst_n), .int_clk_i(int_clk), .ext_clk_i(ext_clk),
    .int_stable_i(int_stb), .ext_stable_i(ext_stb),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ext_osc_on_o(ext_on), .sel_ext_o(sel_ext), .irq_o(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic wr_reg(logic flag_bit, logic [3:0] c);
    wdata = {1'b0, flag_bit, 2'b00, c}; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(output logic [7:0] v);
    rd = 1'b1; v = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic stop_ext(); @(posedge ext_clk); ext_run = 1'b0; @(negedge clk); endtask
  task automatic stop_int(); @(posedge int_clk); int_run = 1'b0; @(negedge clk); endtask

  initial begin
    cyc(3); rst_n = 1'b1; cyc(2);
    // R10 reset state
    chk("R10 rdata", rdata, 8'h00);
    chk("R10 sel", sel_ext, 0);
    chk("R10 irq", irq, 0);
    chk("R10 ext_on", ext_on, 0);

    // R1 monitor enable gated by stability, all combinations
    for (int s = 0; s < 4; s++) begin
      int_stb = s[0]; ext_stb = s[1];
      wr_reg(0, 4'b0100);
      chk("R1 mon_en gate", rdata[2], (s != 0));
      chk("R11 stable bits", rdata[5:4], s[1:0]);
      wr_reg(0, 4'b0000);
      chk("R1 mon_en clear", rdata[2], 0);
    end

    // R11 readback of all control codes
    int_stb = 1; ext_stb = 1;
    for (int v = 0; v < 16; v++) begin
      wr_reg(0, v[3:0]);
      chk("R11 readback", rdata[3:0], v[3:0]);
      chk("R11 ext_on", ext_on, v[0]);
      chk("R11 sel", sel_ext, v[1]);
      chk("R3 no false fail", rdata[6], 0);
    end
    wr_reg(0, 4'b0000);

    // R3/R4/R8 external failure while external selected
    ctl = 4'b1110; wr_reg(0, ctl); cyc(30);
    chk("R3 live no flag", rdata[6], 0);
    stop_ext(); cyc(10);
    chk("R3 not before window", rdata[6], 0);
    cyc(50);
    chk("R3 flag set", rdata[6], 1);
    chk("R4 sel to int", sel_ext, 0);
    chk("R4 bit1", rdata[1], 0);
    chk("R8 irq", irq, 1);
    ctl = 4'b1100;

    // R2 persistence
    int_stb = 0; ext_stb = 0; cyc(3);
    chk("R2 mon_en kept", rdata[2], 1);

    // R7 write 0 without read
    wr_reg(0, ctl);
    chk("R7 no read", rdata[6], 1);
    // R6 write 1 after read
    rd_reg(rv);
    chk("R5 read sees flag", rv[6], 1);
    wr_reg(1, ctl);
    chk("R6 write one", rdata[6], 1);

    // R7 new failure between read and write
    ext_run = 1; cyc(30);
    rd_reg(rv);
    stop_ext(); cyc(60);
    wr_reg(0, ctl);
    chk("R7 fail between", rdata[6], 1);
    chk("R4 sel stays int", sel_ext, 0);

    // R5 proper clear
    rd_reg(rv);
    wr_reg(0, ctl);
    chk("R5 cleared", rdata[6], 0);
    chk("R8 irq low", irq, 0);

    // R9 monitor disabled stops detection
    ext_run = 1; int_stb = 1; ext_stb = 1; cyc(10);
    ctl = 4'b0000; wr_reg(0, ctl);
    stop_int(); cyc(60);
    chk("R9 no flag", rdata[6], 0);
    chk("R9 sel kept", sel_ext, 0);
    int_run = 1; cyc(30);

    // R4/R8 internal failure, interrupt disabled
    ctl = 4'b0100; wr_reg(0, ctl); cyc(30);
    stop_int(); cyc(60);
    chk("R3 int flag", rdata[6], 1);
    chk("R4 sel to ext", sel_ext, 1);
    chk("R8 irq masked", irq, 0);
    ctl = 4'b1110; wr_reg(0, ctl);
    chk("R8 irq enabled", irq, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule